// File: doc/BRIEF.md
# Serial Clock-Chip Command Port

This block is the slave side of a bit-banged serial link to a clock chip's command logic. It holds a 32-byte battery-style RAM and one 8-bit status byte. A host toggles three pins: an enable, a serial clock and a data line. The block returns one data bit on its serial output. Every exchange is a fixed 16-bit frame. The first eight bits name an operation and the last eight carry or return a byte.

The range of the command byte selects the operation. One range reads a RAM cell and another range writes one. A single code returns the status byte. A single control code can clear the status flags and send a one-cycle clear strobe to an interrupt-status bit held elsewhere. All pins are synchronous to the system clock. Serial clock edges are detected by comparing the pin with its registered copy.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the serial output and the clear strobe are 0, the status byte is 0x90 and every RAM byte reads 0x00.
- R2: A bit is taken from the data input only when the serial clock goes from 1 to 0 while enable is 1. Changes of the data input while the serial clock is high, and rising clock edges, have no effect.
- R3: The first eight taken bits form the command byte and the next eight form the data byte, both most significant bit first.
- R4: Commands 0x00 to 0x1F return the RAM byte at address cmd[4:0]. Let k (0 to 7) count the data bits already taken in the frame. Before data bit k is taken, the serial output shows bit 7-k of the selected byte. Outside the data phase the output is 0.
- R5: Commands 0x80 to 0x9F store the received data byte at RAM address cmd-0x80, at the falling edge that completes the 16th bit.
- R6: Command 0x30 returns the status byte. Command 0x31 and commands 0x20 to 0x2F return 0x00.
- R7: Command 0xB1 with data bit 2 set clears status bits 4 and 3 (mask 0x18) at frame completion and raises the clear strobe for exactly one cycle. With data bit 2 clear it does nothing.
- R8: Driving enable to 0 aborts the frame. The bit count, command and data are cleared and a partial frame writes nothing.
- R9: Clock edges after the 16th bit are ignored until enable goes to 0 and back to 1.
- R10: Any other command returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_i | input | 1 | Frame enable, active high |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out during the data phase |
| irq_clr_o | output | 1 | One-cycle strobe that clears an external interrupt-status bit |

## Verification
A falling serial clock is seen at the first system clock edge after the pin drops. The bit count, command, data and the next output bit take their new values at that edge. A RAM write, a status clear or the clear strobe also happens at that edge when it completes bit 16, so the strobe is visible one cycle after the final clock fall. The bench changes its inputs at the falling system clock edge and holds each serial clock level for two cycles. It samples the output bit just before it drops the serial clock, which lets the count settle after the previous fall. It counts strobe cycles on every falling system clock edge. Stored and cleared values are checked through later read frames, never through internal state.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(BYTE_W);
  localparam int ADDR_W     = 5;
  localparam int RAM_DEPTH  = 1 << ADDR_W;

  localparam logic [BYTE_W-1:0] STAT_RD_CODE  = 8'h30;
  localparam logic [BYTE_W-1:0] CTRL_WR_CODE  = 8'hB1;
  localparam logic [BYTE_W-1:0] STAT_CLR_MASK = 8'h18;
  localparam int                CTRL_CLR_BIT  = 2;

  typedef enum logic [2:0] {
    OP_RAM_RD,
    OP_RAM_WR,
    OP_STAT_RD,
    OP_CTRL_WR,
    OP_NONE
  } op_kind_e;

  function automatic op_kind_e classify(input logic [BYTE_W-1:0] c);
    op_kind_e k;
    if (c[7:5] == 3'b000)       k = OP_RAM_RD;
    else if (c[7:5] == 3'b100)  k = OP_RAM_WR;
    else if (c == STAT_RD_CODE) k = OP_STAT_RD;
    else if (c == CTRL_WR_CODE) k = OP_CTRL_WR;
    else                        k = OP_NONE;
    return k;
  endfunction
endpackage

// File: rtl/rtcs_edge.sv
module rtcs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end

  assign fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/rtcs_frame.sv
module rtcs_frame
  import rtcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] wbyte_o
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CMD_BITS  = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              step;

  assign step = ce_i & fall_i & (cnt_q < FULL_CNT);

  always_comb begin
    cnt_d = cnt_q;
    cmd_d = cmd_q;
    dat_d = dat_q;
    if (!ce_i) begin
      cnt_d = '0;
      cmd_d = '0;
      dat_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < CMD_BITS) cmd_d = {cmd_q[BYTE_W-2:0], sdi_i};
      else                  dat_d = {dat_q[BYTE_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmd_q <= '0;
      dat_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cmd_q <= cmd_d;
      dat_q <= dat_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign cmd_o    = cmd_q;
  assign commit_o = step & (cnt_q == LAST_BIT);
  assign wbyte_o  = {dat_q[BYTE_W-2:0], sdi_i};
endmodule

// File: rtl/rtcs_store.sv
module rtcs_store
  import rtcs_pkg::*;
#(
  parameter logic [7:0] STATUS_INIT = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic              sdo_o,
  output logic              irq_clr_o
);
  localparam logic [CNT_W-1:0] DATA_LO = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DATA_HI = CNT_W'(FRAME_BITS);

  op_kind_e          kind;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] mem_q [RAM_DEPTH];
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic              irq_q, irq_d;
  logic [BYTE_W-1:0] rd_byte;
  logic              mem_we;
  logic              in_data;
  logic [IDX_W-1:0]  sel;

  assign kind   = classify(cmd_i);
  assign addr   = cmd_i[ADDR_W-1:0];
  assign mem_we = commit_i & (kind == OP_RAM_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) mem_q[i] <= '0;
    end else if (mem_we) begin
      mem_q[addr] <= wbyte_i;
    end
  end

  always_comb begin
    stat_d = stat_q;
    irq_d  = 1'b0;
    if (commit_i && kind == OP_CTRL_WR && wbyte_i[CTRL_CLR_BIT]) begin
      stat_d = stat_q & ~STAT_CLR_MASK;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STATUS_INIT;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (kind)
      OP_RAM_RD:  rd_byte = mem_q[addr];
      OP_STAT_RD: rd_byte = stat_q;
      default:    rd_byte = '0;
    endcase
  end

  assign in_data   = (cnt_i >= DATA_LO) && (cnt_i < DATA_HI);
  assign sel       = ~cnt_i[IDX_W-1:0];
  assign sdo_o     = in_data & rd_byte[sel];
  assign irq_clr_o = irq_q;
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtcs_pkg::*;
#(
  parameter logic [7:0] STATUS_INIT = 8'h90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic irq_clr_o
);
  logic              fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] cmd;
  logic              commit;
  logic [BYTE_W-1:0] wbyte;

  rtcs_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .fall_o (fall)
  );

  rtcs_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_i     (ce_i),
    .fall_i   (fall),
    .sdi_i    (sdi_i),
    .cnt_o    (bit_cnt),
    .cmd_o    (cmd),
    .commit_o (commit),
    .wbyte_o  (wbyte)
  );

  rtcs_store #(.STATUS_INIT(STATUS_INIT)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (bit_cnt),
    .cmd_i     (cmd),
    .commit_i  (commit),
    .wbyte_i   (wbyte),
    .sdo_o     (sdo_o),
    .irq_clr_o (irq_clr_o)
  );
endmodule

// File: rtl/rtcs_checker.sv
module rtcs_checker
  import rtcs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ce_i,
  input logic             sclk_i,
  input logic             sdo_o,
  input logic             irq_clr_o,
  input logic [CNT_W-1:0] bit_cnt
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_o |=> !irq_clr_o); // R7

  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_o |-> $past(ce_i)); // R7

  AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_o |-> !$past(sclk_i)); // R2

  AST_ABORT_QUIETS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> !sdo_o); // R8

  AST_ABORT_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> (bit_cnt == '0)); // R8

  AST_FULL_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == CNT_W'(FRAME_BITS)) && ce_i |=> (bit_cnt == CNT_W'(FRAME_BITS))); // R9

  AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS)); // R9
endmodule

bind rtc_serial_slave rtcs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_i      (ce_i),
  .sclk_i    (sclk_i),
  .sdo_o     (sdo_o),
  .irq_clr_o (irq_clr_o),
  .bit_cnt   (bit_cnt)
);

// File: tb/sim_rtc_serial_slave.sv
module sim_rtc_serial_slave;
  localparam int CLK_P = 10;
  localparam int NV    = 16;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] dat;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'h30, 8'h00, 8'h90},  // R6 status after reset
    '{8'h80, 8'hA5, 8'h00},  // R5
    '{8'h9F, 8'h3C, 8'h00},  // R5
    '{8'h8A, 8'h81, 8'h00},  // R5
    '{8'h00, 8'h00, 8'hA5},  // R4
    '{8'h1F, 8'h00, 8'h3C},  // R4
    '{8'h0A, 8'h00, 8'h81},  // R4
    '{8'h31, 8'h00, 8'h00},  // R6
    '{8'h25, 8'h00, 8'h00},  // R6
    '{8'h20, 8'hFF, 8'h00},  // R6
    '{8'hA0, 8'hFF, 8'h00},  // R10 no effect
    '{8'h00, 8'h00, 8'hA5},  // R10 address 0 unchanged
    '{8'hB1, 8'hFB, 8'h00},  // R7 bit 2 clear
    '{8'h30, 8'h00, 8'h90},  // R7 status untouched
    '{8'hB1, 8'h04, 8'h00},  // R7 clear
    '{8'h30, 8'h00, 8'h80}   // R7 mask 0x18 cleared
  };

  logic clk = 1'b0;
  logic rst_n, ce_i, sclk_i, sdi_i;
  logic sdo_o, irq_clr_o;
  int   n_chk = 0;
  int   n_err = 0;
  int   irq_cnt = 0;
  int   cmd_ph_hi = 0;
  logic [7:0] got;

  always #(CLK_P / 2) clk = ~clk;

  rtc_serial_slave u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (ce_i),
    .sclk_i    (sclk_i),
    .sdi_i     (sdi_i),
    .sdo_o     (sdo_o),
    .irq_clr_o (irq_clr_o)
  );

  always @(negedge clk) if (rst_n === 1'b1 && irq_clr_o === 1'b1) irq_cnt++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one serial bit; data is inverted while the clock is high, then fixed before the fall
  task automatic send_bit(input logic b, output logic o);
    @(negedge clk) begin sclk_i = 1'b1; sdi_i = ~b; end
    @(negedge clk) sdi_i = b;
    o = sdo_o;
    @(negedge clk) sclk_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] cmd, input logic [7:0] dat, input int nbits,
                           output logic [7:0] rd);
    logic o;
    rd = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      send_bit(i < 8 ? cmd[7-i] : dat[15-i], o);
      if (i < 8 && o) cmd_ph_hi++;
      if (i >= 8) rd = {rd[6:0], o};
    end
  endtask

  task automatic ce_on;
    @(negedge clk) ce_i = 1'b1;
  endtask

  task automatic ce_off;
    @(negedge clk) ce_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] rd);
    ce_on();
    send_bits(cmd, dat, 16, rd);
    ce_off();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic o;
    rst_n = 1'b0; ce_i = 1'b0; sclk_i = 1'b0; sdi_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sdo in reset", {7'd0, sdo_o}, 8'h00);
    check("R1 strobe in reset", {7'd0, irq_clr_o}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    frame(8'h07, 8'h00, rd);
    check("R1 RAM reset value", rd, 8'h00);

    for (int v = 0; v < NV; v++) begin
      frame(VECS[v].cmd, VECS[v].dat, rd);
      check($sformatf("R4/R5/R6/R7/R10 table vector %0d", v), rd, VECS[v].exp);
      if (v == 13) check("R7 no strobe when bit 2 clear", 8'(irq_cnt), 8'd0);
    end
    check("R7 one strobe cycle", 8'(irq_cnt), 8'd1);
    check("R4 output 0 in command phase", 8'(cmd_ph_hi), 8'd0);

    // R3: MSB-first command order distinguishes 0x01 from 0x10
    frame(8'h81, 8'h01, rd);
    frame(8'h90, 8'h80, rd);
    frame(8'h01, 8'h00, rd);
    check("R3 address 0x01", rd, 8'h01);
    frame(8'h10, 8'h00, rd);
    check("R3 address 0x10", rd, 8'h80);

    // R2: data toggled while clock high must not matter
    frame(8'h8C, 8'h96, rd);
    frame(8'h0C, 8'h00, rd);
    check("R2 falling-edge sampling", rd, 8'h96);

    // R8: abort after 12 bits and after 15 bits
    ce_on(); send_bits(8'h87, 8'h5A, 12, rd); ce_off();
    ce_on(); send_bits(8'h87, 8'h5A, 15, rd); ce_off();
    frame(8'h07, 8'h00, rd);
    check("R8 partial frame writes nothing", rd, 8'h00);
    frame(8'h00, 8'h00, rd);
    check("R8 fresh frame after abort", rd, 8'hA5);
    ce_on(); send_bits(8'hB1, 8'h04, 15, rd); ce_off();
    check("R8 aborted control gives no strobe", 8'(irq_cnt), 8'd1);

    // R9: extra edges after the 16th bit are ignored
    ce_on();
    send_bits(8'h88, 8'h77, 16, rd);
    send_bits(8'h88, 8'h11, 16, rd);
    ce_off();
    frame(8'h08, 8'h00, rd);
    check("R9 extra write ignored", rd, 8'h77);
    ce_on();
    send_bits(8'h08, 8'h00, 16, rd);
    check("R9 read in first frame", rd, 8'h77);
    send_bit(1'b1, o);
    check("R9 output quiet after frame", {7'd0, o}, 8'h00);
    ce_off();

    // R10: unlisted codes leave RAM and status alone
    frame(8'hC5, 8'hFF, rd);
    check("R10 unlisted read value", rd, 8'h00);
    frame(8'h05, 8'h00, rd);
    check("R10 RAM untouched", rd, 8'h00);
    frame(8'h30, 8'h00, rd);
    check("R10 status untouched", rd, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule